// File: doc/BRIEF.md
# Call-Return Delay Sequencer

This block is a delay routine that a state machine can use like a subroutine. A caller state gives a single load strobe. The strobe carries a wait length and the code of the caller state to resume afterwards. The sequencer then runs its own three delay phases: start, wait and end. When the wait is over, it jumps to the stored return code. The destination comes from a register that the caller programs, much like a return address, so any caller state can share the same timed wait.

The current state appears on one code bus. Caller states use the low codes, from 0 up to the fourth-highest value of the bus. The three highest codes belong to the delay phases, in this order: start = all ones minus 2, wait = all ones minus 1, end = all ones. Code 0 is the idle caller state that reset selects. A busy flag marks the time spent inside the delay. Calls do not nest, and only one delay can be in progress at a time.

Top module: `dly_call_seq`

## Requirements
- R1: After reset the state bus shows caller code 0 and busy is low.
- R2: In a caller state, a strobe with a legal return code is accepted at the clock edge. From the next cycle the bus shows the start code (all ones minus 2) and busy is high.
- R3: With a nonzero programmed length N, the start phase lasts one cycle. The wait code (all ones minus 1) follows and is shown for exactly N cycles.
- R4: With a programmed length of zero, the end code (all ones) follows the start phase directly, with no wait cycle.
- R5: The end phase lasts one cycle. After it the bus shows the programmed return code and busy is low, so a call lasts N+2 busy cycles in total.
- R6: Busy is high exactly when the bus shows one of the three delay codes.
- R7: A strobe that arrives while busy is ignored. The running delay keeps its length and its return code.
- R8: A strobe whose return code is one of the three delay codes is ignored, and the caller state does not change.
- R9: The largest length, 2^DLY_W-1, gives exactly that many wait cycles.
- R10: In a caller state with no accepted strobe, the state code stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Call strobe, one cycle |
| loadDelay | input | DLY_W | Number of wait cycles for this call |
| loadReturn | input | ST_W | Caller state code to resume after the delay |
| stateOut | output | ST_W | Current state code |
| busy | output | 1 | High while one of the delay phases is active |

## Verification
The assertions assume that the strobe is a clean, synchronous, single-cycle pulse. They make no assumption about its timing relative to busy or about the legality of its return code, because the block itself has to handle both. The stimulus issues calls only from caller states. It also deliberately sends strobes while busy and strobes that carry a delay-phase return code, so the rejection paths are driven on purpose rather than by accident. Lengths of zero, one, a middle value and the maximum cover the edges of the wait counter.

// File: rtl/dly_call_pkg.sv
package dly_call_pkg;

  typedef enum logic [1:0] {
    PH_CALLER = 2'd0,
    PH_START  = 2'd1,
    PH_WAIT   = 2'd2,
    PH_END    = 2'd3
  } dly_phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRegs;
    logic clrCnt;
    logic incCnt;
    logic takeReturn;
  } dly_strobe_t;

endpackage

// File: rtl/dly_call_ctrl.sv
module dly_call_ctrl
  import dly_call_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadValid,
  input  logic        retOk,
  input  logic        lenZero,
  input  logic        cntLast,
  output dly_strobe_t strobes,
  output dly_phase_t  phase
);

  dly_phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    unique case (phase)
      PH_CALLER: begin
        if (loadValid && retOk) begin
          strobes.loadRegs = 1'b1;
          phaseNext        = PH_START;
        end
      end
      PH_START: begin
        strobes.clrCnt = 1'b1;
        phaseNext      = lenZero ? PH_END : PH_WAIT;
      end
      PH_WAIT: begin
        if (cntLast) begin
          phaseNext = PH_END;
        end else begin
          strobes.incCnt = 1'b1;
        end
      end
      PH_END: begin
        strobes.takeReturn = 1'b1;
        phaseNext          = PH_CALLER;
      end
      default: phaseNext = PH_CALLER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_CALLER;
    end else begin
      phase <= phaseNext;
    end
  end

endmodule

// File: rtl/dly_call_dp.sv
module dly_call_dp
  import dly_call_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int ST_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dly_strobe_t      strobes,
  input  logic [DLY_W-1:0] loadDelay,
  input  logic [ST_W-1:0]  loadReturn,
  output logic             retOk,
  output logic             lenZero,
  output logic             cntLast,
  output logic [ST_W-1:0]  curCode
);

  localparam logic [ST_W-1:0] MAX_CALLER = ST_W'((1 << ST_W) - 4);

  logic [DLY_W-1:0] lenReg;
  logic [ST_W-1:0]  retReg;
  logic [DLY_W-1:0] cnt;

  assign retOk   = (loadReturn <= MAX_CALLER);
  assign lenZero = (lenReg == '0);
  assign cntLast = (cnt == (lenReg - 1'b1));

  // programmed length and return code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
      retReg <= '0;
    end else if (strobes.loadRegs) begin
      lenReg <= loadDelay;
      retReg <= loadReturn;
    end
  end

  // wait counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.clrCnt) begin
      cnt <= '0;
    end else if (strobes.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  // resumed caller state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCode <= '0;
    end else if (strobes.takeReturn) begin
      curCode <= retReg;
    end
  end

endmodule

// File: rtl/dly_call_seq.sv
module dly_call_seq
  import dly_call_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int ST_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic [DLY_W-1:0] loadDelay,
  input  logic [ST_W-1:0]  loadReturn,
  output logic [ST_W-1:0]  stateOut,
  output logic             busy
);

  localparam logic [ST_W-1:0] CODE_END   = ST_W'((1 << ST_W) - 1);
  localparam logic [ST_W-1:0] CODE_WAIT  = ST_W'((1 << ST_W) - 2);
  localparam logic [ST_W-1:0] CODE_START = ST_W'((1 << ST_W) - 3);

  dly_strobe_t     strobes;
  dly_phase_t      phase;
  logic            retOk;
  logic            lenZero;
  logic            cntLast;
  logic [ST_W-1:0] curCode;

  dly_call_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadValid (loadValid),
    .retOk     (retOk),
    .lenZero   (lenZero),
    .cntLast   (cntLast),
    .strobes   (strobes),
    .phase     (phase)
  );

  dly_call_dp #(.DLY_W(DLY_W), .ST_W(ST_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .loadDelay  (loadDelay),
    .loadReturn (loadReturn),
    .retOk      (retOk),
    .lenZero    (lenZero),
    .cntLast    (cntLast),
    .curCode    (curCode)
  );

  always_comb begin
    unique case (phase)
      PH_START: stateOut = CODE_START;
      PH_WAIT:  stateOut = CODE_WAIT;
      PH_END:   stateOut = CODE_END;
      default:  stateOut = curCode;
    endcase
  end

  assign busy = (phase != PH_CALLER);

endmodule

// File: rtl/dly_call_seq_chk.sv
module dly_call_seq_chk #(
  parameter int DLY_W = 8,
  parameter int ST_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadValid,
  input logic [DLY_W-1:0] loadDelay,
  input logic [ST_W-1:0]  loadReturn,
  input logic [ST_W-1:0]  stateOut,
  input logic             busy
);

  localparam logic [ST_W-1:0] K_END   = ST_W'((1 << ST_W) - 1);
  localparam logic [ST_W-1:0] K_WAIT  = ST_W'((1 << ST_W) - 2);
  localparam logic [ST_W-1:0] K_START = ST_W'((1 << ST_W) - 3);
  localparam logic [ST_W-1:0] K_MAXC  = ST_W'((1 << ST_W) - 4);

  logic accepted;
  assign accepted = loadValid && !busy && (loadReturn <= K_MAXC);

  p_enter_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (stateOut == K_START) && busy);

  p_start_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == K_START) |=> (stateOut == K_WAIT) || (stateOut == K_END));

  p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == K_WAIT) |=> (stateOut == K_WAIT) || (stateOut == K_END));

  p_end_leaves_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == K_END) |=> !busy);

  p_busy_codes_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy == (stateOut >= K_START));

  p_bad_return_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadValid && (loadReturn > K_MAXC)) |=> $stable(stateOut));

  p_caller_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !accepted) |=> $stable(stateOut));

  logic unusedBits;
  assign unusedBits = ^loadDelay;

endmodule

bind dly_call_seq dly_call_seq_chk #(.DLY_W(DLY_W), .ST_W(ST_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadValid  (loadValid),
  .loadDelay  (loadDelay),
  .loadReturn (loadReturn),
  .stateOut   (stateOut),
  .busy       (busy)
);

// File: tb/dly_call_seq_tb.sv
`timescale 1ns/1ps
module dly_call_seq_tb;

  localparam int DLY_W = 8;
  localparam int ST_W  = 4;
  localparam logic [ST_W-1:0] E_END   = 4'd15;
  localparam logic [ST_W-1:0] E_WAIT  = 4'd14;
  localparam logic [ST_W-1:0] E_START = 4'd13;

  typedef struct {
    logic [ST_W-1:0] code;
    logic            bsy;
    string           tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             loadValid = 1'b0;
  logic [DLY_W-1:0] loadDelay = '0;
  logic [ST_W-1:0]  loadReturn = '0;
  logic [ST_W-1:0]  stateOut;
  logic             busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [ST_W-1:0] curModel = '0;
  exp_t q[$];

  always #4 clk = ~clk;

  dly_call_seq #(.DLY_W(DLY_W), .ST_W(ST_W)) u_dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadDelay(loadDelay),
    .loadReturn(loadReturn), .stateOut(stateOut), .busy(busy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [ST_W-1:0] c, input logic b, input string t);
    exp_t e;
    e.code = c; e.bsy = b; e.tag = t;
    q.push_back(e);
  endtask

  // monitor: compare state and busy against queued expectations
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(stateOut == e.code, e.tag, int'(stateOut), int'(e.code));
      check(busy == e.bsy, {e.tag, " busy"}, int'(busy), int'(e.bsy));
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: issue one call and queue the expected trace; optional strobe while busy (R7)
  task automatic doCall(input int len, input logic [ST_W-1:0] ret, input bit poke);
    @(negedge clk);
    loadValid = 1'b1; loadDelay = DLY_W'(len); loadReturn = ret;
    @(posedge clk); #1;
    loadValid = 1'b0;
    push(E_START, 1'b1, "R2");
    for (int i = 0; i < len; i++) push(E_WAIT, 1'b1, (len == 255) ? "R9" : "R3");
    push(E_END, 1'b1, (len == 0) ? "R4" : "R5");
    push(ret, 1'b0, poke ? "R7" : "R5");
    push(ret, 1'b0, "R10");
    if (poke) begin
      @(negedge clk); @(negedge clk);
      loadValid = 1'b1; loadDelay = 8'd1; loadReturn = 4'd9;
      @(negedge clk);
      loadValid = 1'b0;
    end
    curModel = ret;
    drain();
  endtask

  // R8: strobe carrying a delay-phase return code
  task automatic badCall(input logic [ST_W-1:0] ret);
    @(negedge clk);
    loadValid = 1'b1; loadDelay = 8'd2; loadReturn = ret;
    @(posedge clk); #1;
    loadValid = 1'b0;
    push(curModel, 1'b0, "R8");
    push(curModel, 1'b0, "R8");
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(stateOut == 4'd0, "R1", int'(stateOut), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(stateOut == 4'd0, "R1 hold", int'(stateOut), 0);
    doCall(3, 4'd5, 0);
    doCall(0, 4'd7, 0);
    doCall(1, 4'd12, 0);
    doCall(6, 4'd2, 1);
    badCall(E_START);
    badCall(E_END);
    doCall(255, 4'd0, 0);
    doCall(2, 4'd11, 0);
    repeat (4) push(4'd11, 1'b0, "R10");
    drain();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule